// File: doc/BRIEF.md
# SPI NOR flash device emulator

This block models the device side of an SPI NOR flash. A small memory array sits inside it; the default size is one kilobyte, and both the array size and the sector size are parameters. The block oversamples the chip-select, serial-clock and data-in lines with its own system clock. It assembles one-byte opcodes and acts on them. It drives serial data out together with an output-enable, which a pad turns into a floating line when the enable is low. The bus uses mode 0: the master samples on the rising edge, and the block changes its output after the falling edge.

Write-type instructions are gated by a write enable latch. A write-type instruction takes effect only when chip select rises on a byte boundary. Program data is held in a page buffer and merged into the array at that moment. The status byte then reports the block as busy for a configurable number of cycles. While busy, only the status read is served.

Opcode map: 06h write enable, 04h write disable, 05h read status, 01h write status, 03h read, 02h page program, D8h sector erase, C7h bulk erase. Any other byte in opcode position makes the rest of the frame ignored. Status byte: bit 0 busy, bit 1 write enable latch, bits 7:2 a user field.

Top module: `spi_flash_emu`

## Requirements
- R1: After reset the status byte reads 00h, the output enable is low and every array byte reads FFh.
- R2: Opcode 06h sets status bit 1 only when chip select rises right after its eighth bit; a frame that ends off that boundary leaves the latch alone. Opcode 04h, under the same rule, clears it.
- R3: Opcode 03h is followed by a 24-bit address, MSB first. Data bytes follow MSB first from successive addresses. The address wraps from the top of the array to 0.
- R4: Address bits at and above log2(MEM_BYTES) are ignored.
- R5: The output enable stays low while the opcode and the address bytes are shifted in.
- R6: Page program, sector erase, bulk erase and status write have no effect while the write enable latch is clear.
- R7: Page program data that runs past the end of a 128-byte page continues at offset 0 of the same page. The upper address bits do not change.
- R8: A programmed byte becomes the old content ANDed with the new data.
- R9: A write-type instruction is discarded, and the latch left unchanged, if chip select rises off a byte boundary or before its required bytes have arrived. Page program needs at least one data byte.
- R10: Opcode D8h sets every byte of the SECTOR_BYTES-aligned sector holding the address to FFh. Opcode C7h sets the whole array to FFh.
- R11: After a write-type instruction takes effect, status bit 0 reads 1 for the configured time. During that time any opcode other than 05h is rejected: a read produces no output and nothing else changes. The latch clears when the busy time ends.
- R12: Opcode 01h copies bits 7:2 of its first data byte into status bits 7:2. Status bits 1:0 cannot be written.
- R13: Raising chip select at any bit of a read ends it and drops the output enable.
- R14: Opcode 05h returns the status byte repeatedly while chip select is low. Each byte is captured as its first bit is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for miso_o; low means the line floats |

## Verification
The end of a busy time and the capture of a status byte can land in the same cycle. When that happens, the busy bit and the write enable latch must drop together, so no status byte may ever show only one of them set. The bench provokes this by starting a long status-read frame at several offsets after a bulk erase. The moment each byte is captured then sweeps across the end of the busy time. The byte stream is judged as 03h values followed only by 00h values, ending in 00h. Reads at the array top and at addresses with high bits set are compared against a bench model that applies the wrap and masking rules arithmetically.

// File: rtl/spi_flash_pkg.sv
package spi_flash_pkg;
  localparam logic [7:0] OP_NONE   = 8'h00;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_WRDI   = 8'h04;
  localparam logic [7:0] OP_RDSR   = 8'h05;
  localparam logic [7:0] OP_WRSR   = 8'h01;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_SERASE = 8'hD8;
  localparam logic [7:0] OP_BERASE = 8'hC7;

  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR, PH_READ, PH_STAT, PH_PROG, PH_WRSR, PH_SKIP
  } phase_e;
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic mosi_i,
  output logic cs_n_o,
  output logic mosi_o,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_rise_o
);
  // bit 0 cs, bit 1 sck, bit 2 mosi
  logic [2:0] stg [STAGES];
  logic [2:0] prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= 3'b001;
      prev <= 3'b001;
    end else begin
      stg[0] <= {mosi_i, sck_i, cs_ni};
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev <= stg[STAGES-1];
    end
  end

  assign cs_n_o     = stg[STAGES-1][0];
  assign mosi_o     = stg[STAGES-1][2];
  assign sck_rise_o = stg[STAGES-1][1] & ~prev[1];
  assign sck_fall_o = ~stg[STAGES-1][1] & prev[1];
  assign cs_rise_o  = stg[STAGES-1][0] & ~prev[0];
endmodule

// File: rtl/sfe_busy.sv
module sfe_busy #(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          busy_o,
  output logic          done_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt <= '0;
    else if (load_i)      cnt <= len_i;
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign busy_o = (cnt != '0);
  assign done_o = (cnt == CW'(1)) && !load_i;

  a_r11_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/spi_flash_emu.sv
module spi_flash_emu
  import spi_flash_pkg::*;
#(
  parameter int MEM_BYTES    = 1024,
  parameter int PAGE_BYTES   = 128,
  parameter int SECTOR_BYTES = 256,
  parameter int T_PROG       = 200,
  parameter int T_SERASE     = 1000,
  parameter int T_BERASE     = 3000,
  parameter int T_WRSR       = 100,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic mosi_i,
  output logic miso_o,
  output logic miso_oe_o
);
  localparam int AW   = $clog2(MEM_BYTES);
  localparam int PW   = $clog2(PAGE_BYTES);
  localparam int SW   = $clog2(SECTOR_BYTES);
  localparam int TM1  = (T_PROG > T_SERASE) ? T_PROG : T_SERASE;
  localparam int TM2  = (T_BERASE > T_WRSR) ? T_BERASE : T_WRSR;
  localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
  localparam int CW   = $clog2(TMAX + 1);

  logic cs_n_s, mosi_s, sck_r, sck_f, cs_r;
  logic busy, busy_done, busy_load;
  logic [CW-1:0] busy_len;

  sfe_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .mosi_i,
    .cs_n_o(cs_n_s), .mosi_o(mosi_s), .sck_rise_o(sck_r),
    .sck_fall_o(sck_f), .cs_rise_o(cs_r)
  );

  sfe_busy #(.CW(CW)) i_busy (
    .clk_i, .rst_ni, .load_i(busy_load), .len_i(busy_len),
    .busy_o(busy), .done_o(busy_done)
  );

  phase_e          phase;
  logic [2:0]      bit_cnt, byte_cnt;
  logic [6:0]      sh;
  logic [7:0]      op_q, cur_tx, tx_byte, rx_byte;
  logic [23:0]     addr_q, addr_n;
  logic [AW-1:0]   rd_addr;
  logic [PW-1:0]   wr_off;
  logic [AW-PW-1:0] page_q;
  logic [5:0]      st_user, wrsr_val;
  logic            wel_q, miso_q, rx_done, aligned;
  logic [7:0]      mem  [MEM_BYTES];
  logic [7:0]      pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pmask;
  logic commit_wren, commit_wrdi, commit_prog, commit_se, commit_be, commit_wrsr;

  assign rx_done = sck_r && !cs_n_s && (bit_cnt == 3'd7);
  assign rx_byte = {sh, mosi_s};
  assign addr_n  = {addr_q[15:0], rx_byte};
  assign tx_byte = (phase == PH_READ) ? mem[rd_addr] : {st_user, wel_q, busy};

  // commit decisions use frame state still held in the cycle cs is seen high
  assign aligned     = cs_r && (bit_cnt == 3'd0);
  assign commit_wren = aligned && op_q == OP_WREN && byte_cnt == 3'd1;
  assign commit_wrdi = aligned && op_q == OP_WRDI && byte_cnt == 3'd1;
  assign commit_be   = aligned && op_q == OP_BERASE && byte_cnt == 3'd1 && wel_q;
  assign commit_se   = aligned && op_q == OP_SERASE && byte_cnt == 3'd4 && wel_q;
  assign commit_prog = aligned && op_q == OP_PROG && byte_cnt >= 3'd5 && wel_q;
  assign commit_wrsr = aligned && op_q == OP_WRSR && byte_cnt >= 3'd2 && wel_q;

  assign busy_load = commit_be | commit_se | commit_prog | commit_wrsr;
  always_comb begin
    busy_len = CW'(T_WRSR);
    if (commit_prog)    busy_len = CW'(T_PROG);
    else if (commit_se) busy_len = CW'(T_SERASE);
    else if (commit_be) busy_len = CW'(T_BERASE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase    <= PH_CMD;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      sh       <= '0;
      op_q     <= OP_NONE;
      addr_q   <= '0;
      rd_addr  <= '0;
      wr_off   <= '0;
      page_q   <= '0;
      wrsr_val <= '0;
      cur_tx   <= '0;
      miso_q   <= 1'b0;
    end else if (cs_n_s) begin
      phase    <= PH_CMD;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      op_q     <= OP_NONE;
    end else begin
      if (sck_r) begin
        bit_cnt <= bit_cnt + 3'd1;
        sh      <= {sh[5:0], mosi_s};
      end
      if (rx_done) begin
        if (byte_cnt != 3'd7) byte_cnt <= byte_cnt + 3'd1;
        unique case (phase)
          PH_CMD: begin
            if (busy && rx_byte != OP_RDSR) begin
              phase <= PH_SKIP;
            end else begin
              op_q <= rx_byte;
              unique case (rx_byte)
                OP_RDSR:                     phase <= PH_STAT;
                OP_READ, OP_PROG, OP_SERASE: phase <= PH_ADDR;
                OP_WRSR:                     phase <= PH_WRSR;
                OP_WREN, OP_WRDI, OP_BERASE: phase <= PH_SKIP;
                default: begin
                  op_q  <= OP_NONE;
                  phase <= PH_SKIP;
                end
              endcase
            end
          end
          PH_ADDR: begin
            addr_q <= addr_n;
            if (byte_cnt == 3'd3) begin
              if (op_q == OP_READ) begin
                phase   <= PH_READ;
                rd_addr <= addr_n[AW-1:0];
              end else if (op_q == OP_PROG) begin
                phase  <= PH_PROG;
                wr_off <= addr_n[PW-1:0];
                page_q <= addr_n[AW-1:PW];
              end else begin
                phase <= PH_SKIP;
              end
            end
          end
          PH_WRSR: if (byte_cnt == 3'd1) wrsr_val <= rx_byte[7:2];
          PH_PROG: wr_off <= wr_off + PW'(1);
          default: ;
        endcase
      end
      if (sck_f && (phase == PH_READ || phase == PH_STAT)) begin
        if (bit_cnt == 3'd0) begin
          cur_tx <= tx_byte;
          miso_q <= tx_byte[7];
          if (phase == PH_READ) rd_addr <= rd_addr + AW'(1);
        end else begin
          miso_q <= cur_tx[3'd7 - bit_cnt];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q   <= 1'b0;
      st_user <= '0;
    end else begin
      if (commit_wren)                    wel_q <= 1'b1;
      else if (commit_wrdi || busy_done)  wel_q <= 1'b0;
      if (commit_wrsr) st_user <= wrsr_val;
    end
  end

  // page buffer: filled during the frame, merged into the array at commit
  always_ff @(posedge clk_i) begin
    if (rx_done && phase == PH_PROG) pbuf[wr_off] <= rx_byte;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pmask <= '0;
    else if (rx_done && phase == PH_CMD && rx_byte == OP_PROG && !busy) pmask <= '0;
    else if (rx_done && phase == PH_PROG) pmask[wr_off] <= 1'b1;
  end

  for (genvar g = 0; g < MEM_BYTES; g++) begin : g_cell
    localparam logic [AW-1:0] IA = AW'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem[g] <= 8'hFF;
      else if (commit_be || (commit_se && IA[AW-1:SW] == addr_q[AW-1:SW]))
        mem[g] <= 8'hFF;
      else if (commit_prog && IA[AW-1:PW] == page_q && pmask[IA[PW-1:0]])
        mem[g] <= mem[g] & pbuf[IA[PW-1:0]];
    end
  end

  assign miso_o    = miso_q;
  assign miso_oe_o = !cs_n_s && (phase == PH_READ || phase == PH_STAT);

  a_r11_reject_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && phase == PH_CMD && busy && rx_byte != OP_RDSR) |=> phase == PH_SKIP);

  a_r11_start_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_load |-> !busy);

  a_r11_wel_with_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> !wel_q);

  a_r7_page_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_PROG && $past(phase == PH_PROG)) |-> $stable(page_q));

  a_r3_top_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_f && !cs_n_s && phase == PH_READ && bit_cnt == 3'd0 && rd_addr == '1)
      |=> rd_addr == '0);

  a_r5_quiet_header: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_CMD || phase == PH_ADDR) |-> !miso_oe_o);
endmodule

// File: tb/test_spi_flash_emu.sv
module test_spi_flash_emu;
  localparam int MEMB = 512;
  localparam int H    = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, oe;
  int   errors = 0, checks = 0;
  bit   finished = 0;
  logic [7:0] model [MEMB];
  logic [7:0] pd [256];
  logic [7:0] st_seq [20];
  bit   last_oe, hdr_oe;

  always #4 clk = ~clk;

  spi_flash_emu #(
    .MEM_BYTES(MEMB), .PAGE_BYTES(128), .SECTOR_BYTES(256),
    .T_PROG(1500), .T_SERASE(900), .T_BERASE(1200), .T_WRSR(400)
  ) i_spi_flash_emu (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    last_oe = 0;
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      tick(H);
      if (oe) last_oe = 1;
      rx[b] = miso;
      sck = 1'b1;
      tick(H);
      sck = 1'b0;
    end
  endtask

  task automatic bits(input logic [7:0] tx, input int n);
    for (int b = 7; b > 7 - n; b--) begin
      mosi = tx[b];
      tick(H);
      sck = 1'b1;
      tick(H);
      sck = 1'b0;
    end
  endtask

  task automatic sel;
    cs_n = 1'b0;
    tick(H);
  endtask

  task automatic desel;
    tick(H);
    cs_n = 1'b1;
    tick(10);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    sel(); xfer(op, r); desel();
  endtask

  task automatic hdr(input logic [7:0] op, input int a);
    logic [7:0] r;
    hdr_oe = 0;
    xfer(op, r); hdr_oe |= last_oe;
    xfer(a[23:16], r); hdr_oe |= last_oe;
    xfer(a[15:8], r);  hdr_oe |= last_oe;
    xfer(a[7:0], r);   hdr_oe |= last_oe;
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] r;
    sel(); xfer(8'h05, r); xfer(8'h00, s); desel();
  endtask

  task automatic rd(input int a, input int n, input string tag);
    logic [7:0] r;
    sel(); hdr(8'h03, a);
    chk("R5 header oe", hdr_oe, 0);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, r);
      chk(tag, r, model[((a % MEMB) + k) % MEMB]);
    end
    desel();
  endtask

  task automatic pp(input int a, input int n, input bit take);
    logic [7:0] r;
    int pg, off;
    sel(); hdr(8'h02, a);
    for (int k = 0; k < n; k++) xfer(pd[k], r);
    desel();
    if (take) begin
      pg  = (a % MEMB) & ~127;
      off = a & 127;
      for (int k = 0; k < n; k++) model[pg | ((off + k) & 127)] &= pd[k];
    end
  endtask

  task automatic wait_idle;
    logic [7:0] s;
    for (int i = 0; i < 100; i++) begin
      rdsr(s);
      if (!s[0]) break;
    end
  endtask

  initial begin
    logic [7:0] s, r;
    bit seen0, bad;
    for (int i = 0; i < MEMB; i++) model[i] = 8'hFF;
    tick(5); rst_n = 1'b1; tick(5);

    // R1
    chk("R1 oe", oe, 0);
    rdsr(s); chk("R1 status", s, 8'h00);
    rd(0, 4, "R1 erased");

    // R2
    cmd1(8'h06); rdsr(s); chk("R2 wren", s, 8'h02);
    cmd1(8'h04); rdsr(s); chk("R2 wrdi", s, 8'h00);
    sel(); xfer(8'h06, r); bits(8'h00, 3); desel();
    rdsr(s); chk("R2 wren off boundary", s, 8'h00);
    sel(); bits(8'h06, 5); desel();
    rdsr(s); chk("R2 wren short", s, 8'h00);

    // R6 program without latch
    pd[0] = 8'h00;
    pp(16, 1, 0);
    rd(16, 1, "R6 prog no wel");

    // page 0 full sweep
    for (int k = 0; k < 128; k++) pd[k] = 8'(k * 37) ^ 8'h5A;
    cmd1(8'h06); pp(0, 128, 1); wait_idle();
    rdsr(s); chk("R11 wel cleared after prog", s, 8'h00);
    rd(0, 128, "R8 page sweep");

    // R8 AND merge
    for (int k = 0; k < 4; k++) pd[k] = 8'h0F << k;
    cmd1(8'h06); pp(0, 4, 1); wait_idle();
    rd(0, 4, "R8 and");

    // R7 page wrap
    for (int k = 0; k < 4; k++) pd[k] = 8'hA1 + 8'(k);
    cmd1(8'h06); pp(9'h17E, 4, 1); wait_idle();
    rd(9'h17E, 2, "R7 wrap tail");
    rd(9'h100, 3, "R7 wrap head");
    rd(9'h180, 1, "R7 next page");

    // R9 discarded frame
    cmd1(8'h06);
    sel(); hdr(8'h02, 64); xfer(8'h00, r); xfer(8'h00, r); bits(8'h00, 4); desel();
    rdsr(s); chk("R9 wel kept", s, 8'h02);
    rd(64, 2, "R9 no change");
    sel(); hdr(8'h02, 65); desel();
    rdsr(s); chk("R9 no data byte", s, 8'h02);
    cmd1(8'h04);

    // R11 busy window
    pd[0] = 8'h00;
    cmd1(8'h06); pp(9'h1C0, 1, 1);
    rdsr(s); chk("R11 busy status", s, 8'h03);
    sel(); hdr(8'h03, 9'h1C0); xfer(8'h00, r); desel();
    chk("R11 read rejected", hdr_oe | last_oe, 0);
    cmd1(8'h04);
    rdsr(s); chk("R11 wrdi rejected", s, 8'h03);
    wait_idle();
    rdsr(s); chk("R11 idle", s, 8'h00);
    rd(9'h1C0, 1, "R11 prog landed");

    // R4, R3
    rd(24'h000205, 3, "R4 high bits");
    rd(24'hFFFE03, 2, "R4 all high");
    rd(9'h1FE, 5, "R3 rollover");

    // R13
    sel(); hdr(8'h03, 9'h100); xfer(8'h00, r); bits(8'h00, 3);
    cs_n = 1'b1; tick(6);
    chk("R13 oe dropped", oe, 0);
    tick(6);
    rd(9'h101, 1, "R13 fresh read");

    // R12
    sel(); xfer(8'h01, r); xfer(8'hFF, r); desel();
    rdsr(s); chk("R12 no wel", s, 8'h00);
    cmd1(8'h06);
    sel(); xfer(8'h01, r); xfer(8'hA7, r); xfer(8'h00, r); desel();
    wait_idle();
    rdsr(s); chk("R12 user bits", s, 8'hA4);
    cmd1(8'h06);
    sel(); xfer(8'h01, r); xfer(8'h00, r); desel();
    wait_idle();
    rdsr(s); chk("R12 cleared", s, 8'h00);

    // R10 sector erase, then full array sweep
    cmd1(8'h06);
    sel(); hdr(8'hD8, 9'h120); desel();
    for (int i = 256; i < 512; i++) model[i] = 8'hFF;
    wait_idle();
    rd(0, MEMB + 2, "R10 sector sweep");

    // R6 erase without latch
    sel(); hdr(8'hD8, 0); desel();
    cmd1(8'hC7);
    rd(0, 2, "R6 erase no wel");

    // R11/R14 collision sweep: status capture across end of bulk erase
    for (int d = 0; d < 4; d++) begin
      cmd1(8'h06); cmd1(8'hC7);
      for (int i = 0; i < MEMB; i++) model[i] = 8'hFF;
      tick(d * 24);
      sel(); xfer(8'h05, r);
      for (int k = 0; k < 20; k++) xfer(8'h00, st_seq[k]);
      desel();
      seen0 = 0; bad = 0;
      for (int k = 0; k < 20; k++) begin
        if (st_seq[k] == 8'h00) seen0 = 1;
        else if (st_seq[k] != 8'h03 || seen0) bad = 1;
      end
      chk("R14 first busy", st_seq[0], 8'h03);
      chk("R11 coherent drop", bad, 0);
      chk("R11 ends idle", st_seq[19], 8'h00);
    end
    rd(0, 3, "R10 bulk");
    rd(9'h17E, 4, "R10 bulk top");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule